// File: doc/BRIEF.md
# Clock-Slave Synchronous Serial Transmitter

This block sends parallel words from a host bus as a serial bit stream. An external device supplies the shift clock. A one-word holding register sits in front of a shift register, so the host can queue the next word while the current one is still going out. The block takes no timing from the host core, so shifting goes on while the core is halted. When a queued word moves into the shift register, the buffer-empty flag rises. If the interrupt enable is set, the resulting request can wake the core.

The external clock is brought into the system clock domain through a two-flop synchronizer, and its edges are detected there. Each detected falling edge places the next bit on the data line, so the bit is steady when the external master samples it on the rising edge. Words are eight bits, or nine bits when the extended-word mode is set at the time of the write. Clearing any of the enabling conditions empties both registers and returns the line to its idle level.

Top module: `sync_slave_tx`

## Requirements
- R1: The transmitter is active only when all of these hold: `port_en`=1, `sync_mode`=1, `clk_src`=0, `tx_en`=1, `rx_single_en`=0 and `rx_cont_en`=0. While it is inactive, writes are ignored, `sdo` stays at the idle level 1 and no bit is sent.
- R2: A write taken at a clock edge clears `buf_empty` after that edge. If the shifter is idle, the word moves into the shifter at the next edge and `buf_empty` returns to 1. `sdo` stays at 1 until the first falling edge of the shift clock.
- R3: Each falling edge of `sck_in`, after synchronization, presents the next bit on `sdo` within three system clocks. The order is least significant bit first: bit 0 through bit 7. `sdo` changes at no other time while the block is active.
- R4: A word written while another word is shifting stays in the holding register, and `buf_empty` stays 0 until the current word's last bit has been presented.
- R5: Once the falling edge that presents the current word's last bit has passed, the held word moves into the shifter and `buf_empty` becomes 1. Its bit 0 follows on the next falling edge, so two queued words leave with no gap between them.
- R6: With nothing held, the falling edge after a word's last bit returns `sdo` to 1.
- R7: When `nine_bit_mode` is 1 at the time of a write, the word has nine bits. The ninth bit is the value of `ninth_bit` sampled with the write, and it is sent after bit 7.
- R8: `irq` is 1 exactly when `tx_ie`=1, `buf_empty`=1 and the transmitter is active.
- R9: When the transmitter becomes inactive, the shift and holding registers are emptied. From the next cycle on, `sdo`=1 and `buf_empty`=1, and a word that was shifting or queued is never sent after re-enabling.
- R10: After reset, `sdo`=1, `buf_empty`=1 and `irq`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| port_en | input | 1 | Serial port enable |
| sync_mode | input | 1 | Synchronous mode select |
| clk_src | input | 1 | Clock source: 0 for an external clock (slave), 1 for an internal clock |
| tx_en | input | 1 | Transmit enable |
| rx_single_en | input | 1 | Single-word receive enable; must be 0 to transmit |
| rx_cont_en | input | 1 | Continuous receive enable; must be 0 to transmit |
| nine_bit_mode | input | 1 | Selects nine-bit words, sampled at each write |
| ninth_bit | input | 1 | Ninth data bit, sampled at each write |
| tx_ie | input | 1 | Transmit interrupt enable |
| wr_valid | input | 1 | Host write strobe for the holding register |
| wr_data | input | DATA_W | Host write data |
| sck_in | input | 1 | External shift clock |
| sdo | output | 1 | Serial data out, idle level 1 |
| buf_empty | output | 1 | Holding register empty flag |
| irq | output | 1 | Transmit interrupt request |

## Verification
On every cycle, the assertions check four things. A write clears the empty flag. Leaving the active state forces the line and the flag back to idle. `sdo` moves only after a detected falling edge. The interrupt never fires without both its enable and the empty flag. Only the bench's scenarios can show the rest: bit order, the seamless handover of a queued word, the ninth bit, and that flushed or blocked words never come out. For this the bench compares the serial stream at each rising clock edge with the bits it predicted from its own writes.

// File: rtl/sync_slave_tx.sv
module sync_slave_tx #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              port_en,
  input  logic              sync_mode,
  input  logic              clk_src,
  input  logic              tx_en,
  input  logic              rx_single_en,
  input  logic              rx_cont_en,
  input  logic              nine_bit_mode,
  input  logic              ninth_bit,
  input  logic              tx_ie,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              sck_in,
  output logic              sdo,
  output logic              buf_empty,
  output logic              irq
);
  localparam int WORD_W = DATA_W + 1;
  localparam int CNT_W  = $clog2(WORD_W + 1);

  logic [2:0]        sck_sync;
  logic [WORD_W-1:0] hold_q, shift_q;
  logic              hold_full, hold_nine, sdo_q;
  logic [CNT_W-1:0]  bits_left;

  wire active   = port_en & sync_mode & ~clk_src & tx_en & ~rx_single_en & ~rx_cont_en;
  wire sck_fall = sck_sync[2] & ~sck_sync[1];
  wire busy     = bits_left != '0;
  wire load     = hold_full & ~busy & ~sck_fall;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sck_sync <= '1;
    else        sck_sync <= {sck_sync[1:0], sck_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q    <= '0;
      hold_nine <= 1'b0;
      hold_full <= 1'b0;
      shift_q   <= '1;
      bits_left <= '0;
      sdo_q     <= 1'b1;
    end else if (!active) begin
      hold_full <= 1'b0;
      shift_q   <= '1;
      bits_left <= '0;
      sdo_q     <= 1'b1;
    end else begin
      if (wr_valid) begin
        hold_q    <= {ninth_bit, wr_data};
        hold_nine <= nine_bit_mode;
        hold_full <= 1'b1;
      end else if (load) begin
        hold_full <= 1'b0;
      end
      if (load) begin
        shift_q   <= hold_q;
        bits_left <= hold_nine ? CNT_W'(WORD_W) : CNT_W'(DATA_W);
      end else if (sck_fall) begin
        sdo_q <= busy ? shift_q[0] : 1'b1;
        if (busy) begin
          shift_q   <= {1'b1, shift_q[WORD_W-1:1]};
          bits_left <= bits_left - 1'b1;
        end
      end
    end
  end

  assign sdo       = sdo_q;
  assign buf_empty = ~hold_full;
  assign irq       = tx_ie & buf_empty & active;
endmodule

module sync_slave_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic port_en,
  input logic sync_mode,
  input logic clk_src,
  input logic tx_en,
  input logic rx_single_en,
  input logic rx_cont_en,
  input logic tx_ie,
  input logic wr_valid,
  input logic sck_in,
  input logic sdo,
  input logic buf_empty,
  input logic irq
);
  logic [2:0] c_sync;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) c_sync <= '1;
    else        c_sync <= {c_sync[1:0], sck_in};

  wire c_fall   = c_sync[2] & ~c_sync[1];
  wire c_active = port_en & sync_mode & ~clk_src & tx_en & ~rx_single_en & ~rx_cont_en;

  p_idle_when_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !c_active |=> (sdo && buf_empty));

  p_write_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (c_active && wr_valid) |=> !buf_empty);

  p_sdo_moves_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (c_active && !c_fall) |=> $stable(sdo));

  p_irq_needs_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (tx_ie && buf_empty));
endmodule

bind sync_slave_tx sync_slave_tx_chk i_chk (.*);

// File: tb/test_sync_slave_tx.sv
module test_sync_slave_tx;
  logic clk = 1'b0, rst_n = 1'b0;
  logic port_en = 0, sync_mode = 0, clk_src = 0, tx_en = 0;
  logic rx_single_en = 0, rx_cont_en = 0, nine_bit_mode = 0, ninth_bit = 0;
  logic tx_ie = 0, wr_valid = 0, sck_in = 1'b1;
  logic [7:0] wr_data = '0;
  logic sdo, buf_empty, irq;
  int checks = 0, errors = 0, cycles = 0;
  bit exp_q[$];

  always #2 clk = ~clk;

  sync_slave_tx i_sync_slave_tx (.*);

  function automatic bit bench_active();
    return port_en & sync_mode & ~clk_src & tx_en & ~rx_single_en & ~rx_cont_en;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_word(logic [7:0] d, logic nb);
    @(negedge clk);
    wr_data = d; ninth_bit = nb; wr_valid = 1'b1;
    if (bench_active()) begin
      for (int i = 0; i < 8; i++) exp_q.push_back(d[i]);
      if (nine_bit_mode) exp_q.push_back(nb);
    end
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic sck_cycle(string req);
    bit exp;
    sck_in = 1'b0;
    repeat (8) @(negedge clk);
    exp = (exp_q.size() > 0) ? exp_q.pop_front() : 1'b1;
    check(req, sdo, exp);
    sck_in = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++;
        $display("FAIL watchdog actual=%0d expected<100000", cycles);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 sdo", sdo, 1);
    check("R10 buf_empty", buf_empty, 1);
    check("R10 irq", irq, 0);

    tx_ie = 1'b1;
    @(negedge clk);
    check("R8 irq off when inactive", irq, 0);
    port_en = 1; sync_mode = 1; tx_en = 1;
    @(negedge clk);
    check("R8 irq when empty", irq, 1);
    tx_ie = 1'b0;
    @(negedge clk);
    check("R8 irq masked", irq, 0);

    // R2: single word from idle
    @(negedge clk);
    wr_data = 8'hA5; wr_valid = 1'b1;
    for (int i = 0; i < 8; i++) exp_q.push_back(wr_data[i]);
    @(negedge clk);
    wr_valid = 1'b0;
    check("R2 flag cleared by write", buf_empty, 0);
    @(negedge clk);
    check("R2 flag set after transfer", buf_empty, 1);
    check("R2 line idle before first edge", sdo, 1);
    for (int i = 0; i < 8; i++) sck_cycle("R3 bit order");
    sck_cycle("R6 idle after last bit");

    // R4/R5: queued second word
    write_word(8'h3C, 1'b0);
    repeat (2) @(negedge clk);
    write_word(8'hC3, 1'b0);
    check("R4 flag clear while held", buf_empty, 0);
    for (int i = 0; i < 7; i++) sck_cycle("R3 first word");
    check("R4 flag still clear", buf_empty, 0);
    sck_cycle("R3 last bit of first word");
    check("R5 flag set after handover", buf_empty, 1);
    tx_ie = 1'b1;
    @(negedge clk);
    check("R8 irq on handover", irq, 1);
    tx_ie = 1'b0;
    for (int i = 0; i < 8; i++) sck_cycle("R5 second word back to back");
    sck_cycle("R6 idle after second word");

    // R7: nine-bit words
    nine_bit_mode = 1'b1;
    write_word(8'h5A, 1'b1);
    repeat (2) @(negedge clk);
    for (int i = 0; i < 9; i++) sck_cycle("R7 nine bit word");
    sck_cycle("R6 idle after nine bits");
    write_word(8'hFF, 1'b0);
    repeat (2) @(negedge clk);
    for (int i = 0; i < 9; i++) sck_cycle("R7 ninth bit zero");
    nine_bit_mode = 1'b0;

    // R1: blocked by master clock source, then by receive enable
    clk_src = 1'b1;
    write_word(8'h00, 1'b0);
    check("R1 master source flag", buf_empty, 1);
    for (int i = 0; i < 9; i++) sck_cycle("R1 master source ignored");
    clk_src = 1'b0;
    rx_cont_en = 1'b1;
    write_word(8'h00, 1'b0);
    for (int i = 0; i < 9; i++) sck_cycle("R1 receive enabled ignored");
    rx_cont_en = 1'b0;
    rx_single_en = 1'b1;
    write_word(8'h00, 1'b0);
    for (int i = 0; i < 9; i++) sck_cycle("R1 single receive ignored");
    rx_single_en = 1'b0;

    // R9: flush mid word
    write_word(8'h00, 1'b0);
    repeat (2) @(negedge clk);
    write_word(8'h00, 1'b0);
    for (int i = 0; i < 3; i++) sck_cycle("R3 before flush");
    tx_en = 1'b0;
    repeat (2) @(negedge clk);
    check("R9 line idle after flush", sdo, 1);
    check("R9 flag after flush", buf_empty, 1);
    exp_q.delete();
    tx_en = 1'b1;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 18; i++) sck_cycle("R9 flushed words never sent");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule